// File: doc/BRIEF.md
# Serial Link Startup Handshake Controller

This block runs the bring-up exchange of a point-to-point serial link. A slow return path carries two status bits from the receiver back to the local transmitter, and those bits move the link through three stages. In the first stage the transmitter sends fill word 0. In the second it sends fill word 1. In the last stage host data is allowed onto the line.

On the receive side the block tracks three flags. The first says the transmitter clock is locked. The second says the receiver's word alignment has found frame lock. The third says the receiver has seen fill word 1. Alignment detection, serialization and line coding are outside the block; their results arrive as input flags. On the transmit side the block registers the outgoing word, choosing between the two fill words and host data. It also hands the host a ready flag, which is the data enable passed through two flip-flops.

A power-on reset sets everything back to the fill-0 stage. A separate reset for the receiver state machine may be tied inactive. With that reset tied off, the link recovers on its own after it loses lock.

Top module: `linkStartupCtrl`

## Requirements
- R1: While `rstN` is low, and right after it is released, `stat1`=0, `stat0`=0, `dataEnable`=0, `readyForData`=0 and `txWord`=FILL0_PAT.
- R2: `rxEnabled` is `txLocked` delayed by one clock. While `txLocked` is low, the status stays 00 even when `frameLocked` is high.
- R3: Whenever the status is 00 (encoding {stat1,stat0}), `txWord` carries FILL0_PAT on the following cycle.
- R4: In status 00, with `txLocked`, `frameLocked` and `rxSmRstN` all high at an edge, the status becomes 10 at that edge. From then on `txWord` carries FILL1_PAT.
- R5: `freqDetEn` is high only when `rxEnabled` is high and `stat1` is low. A high `stat1` means the receiver is in active mode.
- R6: In status 10, a high `fill1Seen` at an edge moves the status to 11, and `dataEnable` (equal to `stat0`) goes high.
- R7: `readyForData` rises exactly two clock edges after `stat0` rises. It is never high in the cycle in which `stat0` rises.
- R8: A low `txLocked` or a low `frameLocked` at any edge clears both status bits and `readyForData` at that edge.
- R9: While `dataEnable` is low, `hostData` has no effect. The next `txWord` is the fill word chosen by `stat1`. While `dataEnable` is high, the next `txWord` equals `hostData`.
- R10: A low `rxSmRstN` at an edge forces status 00. With `rxSmRstN` held high, the link climbs back to status 11 once lock returns, with no other action.
- R11: The status encoding 01 never appears on the outputs. If it is ever held internally, it is forced to 00 at the next edge.
- R12: The stages are taken strictly in order. A high `fill1Seen` in status 00 does not skip ahead to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit-domain clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| rxSmRstN | input | 1 | Receiver state-machine reset, active low; may be tied high |
| txLocked | input | 1 | Transmitter clock is locked |
| frameLocked | input | 1 | Receiver has frame lock |
| fill1Seen | input | 1 | Receiver is detecting fill word 1 |
| hostData | input | WORD_W | Host word to send once data is enabled |
| stat1 | output | 1 | Status bit 1 (frame locked, send fill 1) |
| stat0 | output | 1 | Status bit 0 (fill 1 received, data enabled) |
| dataEnable | output | 1 | Transmitter data enable |
| readyForData | output | 1 | Retimed ready flag to the host |
| rxEnabled | output | 1 | Receiver enabled (registered transmitter lock) |
| freqDetEn | output | 1 | Receiver frequency detector enable |
| txWord | output | WORD_W | Registered word presented to the serializer |

## Verification
The ordered bring-up is driven with `frameLocked` raised before `txLocked`, and with `fill1Seen` raised too early. These runs separate gating by clock lock and strict ordering from a machine that reacts to the flags in any order. Single-cycle drops of each lock flag, and pulses of the receiver reset while in the data stage, separate immediate teardown from a lazy one. A re-acquire afterwards confirms that recovery needs no extra action. Changing `hostData` on every cycle across the whole run shows that it leaks through only in the data stage, and only one cycle late. A long stretch of random flag activity, compared every clock against a behavioural model, checks the two-cycle ready delay against every way the stage can be entered or left.

// File: rtl/linkStartupPkg.sv
package linkStartupPkg;

  // Status code {stat1, stat0}. 2'b01 is never a legal resting value.
  typedef enum logic [1:0] {
    ST_FILL0 = 2'b00,
    ST_BAD   = 2'b01,
    ST_FILL1 = 2'b10,
    ST_DATA  = 2'b11
  } linkStat_e;

  // Strobes from the sequencer to the transmit datapath.
  typedef struct packed {
    logic selData;   // pass host data through
    logic selFill1;  // choose fill word 1 over fill word 0
    logic flush;     // abort: clear the ready retiming chain
  } pathStrobe_t;

endpackage

// File: rtl/linkStartupFsm.sv
module linkStartupFsm
  import linkStartupPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxSmRstN,
  input  logic        txLocked,
  input  logic        frameLocked,
  input  logic        fill1Seen,
  output linkStat_e   statQ,
  output pathStrobe_t strobe,
  output logic        rxEnabled,
  output logic        freqDetEn
);

  linkStat_e statD;
  logic      abortLink;

  always_comb begin
    abortLink = !rxSmRstN || !txLocked || !frameLocked;
    statD     = statQ;
    if (abortLink) begin
      statD = ST_FILL0;
    end else begin
      case (statQ)
        ST_FILL0: statD = ST_FILL1;
        ST_FILL1: statD = fill1Seen ? ST_DATA : ST_FILL1;
        ST_DATA:  statD = ST_DATA;
        default:  statD = ST_FILL0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ     <= ST_FILL0;
      rxEnabled <= 1'b0;
    end else begin
      statQ     <= statD;
      rxEnabled <= txLocked;
    end
  end

  always_comb begin
    strobe.selData  = (statQ == ST_DATA);
    strobe.selFill1 = statQ[1];
    strobe.flush    = abortLink;
    freqDetEn       = rxEnabled && !statQ[1];
  end

endmodule

// File: rtl/linkStartupWordPath.sv
module linkStartupWordPath
  import linkStartupPkg::*;
#(
  parameter int unsigned           WORD_W    = 16,
  parameter logic [WORD_W-1:0]     FILL0_PAT = 16'h0F0F,
  parameter logic [WORD_W-1:0]     FILL1_PAT = 16'h3C3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [WORD_W-1:0] hostData,
  output logic [WORD_W-1:0] txWord
);

  logic [WORD_W-1:0] fillWord;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    fillWord = strobe.selFill1 ? FILL1_PAT : FILL0_PAT;
    nextWord = strobe.selData ? hostData : fillWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txWord <= FILL0_PAT;
    else       txWord <= nextWord;
  end

endmodule

// File: rtl/linkStartupRetime.sv
module linkStartupRetime #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      pipe[0] <= 1'b0;
        else if (flush) pipe[0] <= 1'b0;
        else            pipe[0] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      pipe[i] <= 1'b0;
        else if (flush) pipe[i] <= 1'b0;
        else            pipe[i] <= pipe[i-1] && din;
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/linkStartupCtrl.sv
module linkStartupCtrl
  import linkStartupPkg::*;
#(
  parameter int unsigned       WORD_W     = 16,
  parameter logic [WORD_W-1:0] FILL0_PAT  = 16'h0F0F,
  parameter logic [WORD_W-1:0] FILL1_PAT  = 16'h3C3C,
  parameter int unsigned       RFD_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxSmRstN,
  input  logic              txLocked,
  input  logic              frameLocked,
  input  logic              fill1Seen,
  input  logic [WORD_W-1:0] hostData,
  output logic              stat1,
  output logic              stat0,
  output logic              dataEnable,
  output logic              readyForData,
  output logic              rxEnabled,
  output logic              freqDetEn,
  output logic [WORD_W-1:0] txWord
);

  linkStat_e   statQ;
  pathStrobe_t strobe;

  linkStartupFsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .rxSmRstN   (rxSmRstN),
    .txLocked   (txLocked),
    .frameLocked(frameLocked),
    .fill1Seen  (fill1Seen),
    .statQ      (statQ),
    .strobe     (strobe),
    .rxEnabled  (rxEnabled),
    .freqDetEn  (freqDetEn)
  );

  linkStartupWordPath #(
    .WORD_W   (WORD_W),
    .FILL0_PAT(FILL0_PAT),
    .FILL1_PAT(FILL1_PAT)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .hostData(hostData),
    .txWord  (txWord)
  );

  linkStartupRetime #(
    .STAGES(RFD_STAGES)
  ) u_rfd (
    .clk  (clk),
    .rstN (rstN),
    .flush(strobe.flush),
    .din  (statQ[0]),
    .dout (readyForData)
  );

  assign stat1      = statQ[1];
  assign stat0      = statQ[0];
  assign dataEnable = statQ[0];

endmodule

// File: rtl/linkStartupChk.sv
module linkStartupChk #(
  parameter int unsigned       WORD_W    = 16,
  parameter logic [WORD_W-1:0] FILL0_PAT = 16'h0F0F,
  parameter logic [WORD_W-1:0] FILL1_PAT = 16'h3C3C
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxSmRstN,
  input logic              txLocked,
  input logic              frameLocked,
  input logic              fill1Seen,
  input logic [WORD_W-1:0] hostData,
  input logic              stat1,
  input logic              stat0,
  input logic              dataEnable,
  input logic              readyForData,
  input logic              rxEnabled,
  input logic              freqDetEn,
  input logic [WORD_W-1:0] txWord
);

  // R11
  no_illegal_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!stat1 && stat0));

  // R8
  lock_loss_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txLocked || !frameLocked) |=> (!stat1 && !stat0 && !readyForData));

  // R4
  frame_lock_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stat1 && !stat0 && txLocked && frameLocked && rxSmRstN) |=> (stat1 && !stat0));

  // R6
  data_entry_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat0) |-> ($past(stat1) && $past(fill1Seen)));

  // R7
  rfd_not_same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat0) |-> !readyForData);

  // R7
  rfd_needs_history_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyForData |-> ($past(dataEnable) && $past(dataEnable, 2)));

  // R5
  fd_off_in_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat1 |-> !freqDetEn);

  // R2
  rx_follows_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txLocked |=> !rxEnabled);

  // R9
  host_passes_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataEnable |=> (txWord == $past(hostData)));

  // R3
  fill0_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stat1 && !stat0) |=> (txWord == FILL0_PAT));

  // R9
  fill1_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stat1 && !dataEnable) |=> (txWord == FILL1_PAT));

  // R10
  rx_reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxSmRstN |=> (!stat1 && !stat0));

endmodule

bind linkStartupCtrl linkStartupChk #(
  .WORD_W   (WORD_W),
  .FILL0_PAT(FILL0_PAT),
  .FILL1_PAT(FILL1_PAT)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rxSmRstN    (rxSmRstN),
  .txLocked    (txLocked),
  .frameLocked (frameLocked),
  .fill1Seen   (fill1Seen),
  .hostData    (hostData),
  .stat1       (stat1),
  .stat0       (stat0),
  .dataEnable  (dataEnable),
  .readyForData(readyForData),
  .rxEnabled   (rxEnabled),
  .freqDetEn   (freqDetEn),
  .txWord      (txWord)
);

// File: tb/linkStartupCtrl_tb_top.sv
`timescale 1ns/1ps
module linkStartupCtrl_tb_top;

  localparam int          W  = 16;
  localparam logic [W-1:0] F0 = 16'h0F0F;
  localparam logic [W-1:0] F1 = 16'h3C3C;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rxSmRstN = 1'b1;
  logic         txLocked = 1'b0;
  logic         frameLocked = 1'b0;
  logic         fill1Seen = 1'b0;
  logic [W-1:0] hostData = '0;
  logic         stat1, stat0, dataEnable, readyForData, rxEnabled, freqDetEn;
  logic [W-1:0] txWord;

  always #10 clk = ~clk;  // 50 MHz

  linkStartupCtrl #(.WORD_W(W), .FILL0_PAT(F0), .FILL1_PAT(F1)) dut_i (
    .clk(clk), .rstN(rstN), .rxSmRstN(rxSmRstN), .txLocked(txLocked),
    .frameLocked(frameLocked), .fill1Seen(fill1Seen), .hostData(hostData),
    .stat1(stat1), .stat0(stat0), .dataEnable(dataEnable),
    .readyForData(readyForData), .rxEnabled(rxEnabled),
    .freqDetEn(freqDetEn), .txWord(txWord)
  );

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit started = 0;
  bit done    = 0;

  // Behavioural reference: stage as an integer 0 (fill0), 2 (fill1), 3 (data).
  int           mStage = 0;
  bit           mRx = 0;
  bit           mRdy = 0;
  int           rdyHist[$];          // data-enable history since last abort
  logic [W-1:0] mWord = F0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStage = 0; mRx = 0; mRdy = 0; mWord = F0;
      rdyHist.delete();
    end else begin
      bit abortNow;
      int oldStage;
      abortNow = !rxSmRstN || !txLocked || !frameLocked;
      oldStage = mStage;
      mWord = (oldStage == 3) ? hostData : ((oldStage == 2) ? F1 : F0);
      mRx   = txLocked;
      if (abortNow) begin
        rdyHist.delete();
        mRdy = 0;
      end else begin
        if (oldStage == 3) rdyHist.push_back(1);
        else rdyHist.delete();
        mRdy = (rdyHist.size() >= 2);
      end
      if (abortNow)                        mStage = 0;
      else if (oldStage == 0)              mStage = 2;
      else if (oldStage == 2 && fill1Seen) mStage = 3;
      cycles++;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Full comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R4 stat1",        {15'b0, stat1},        {15'b0, mStage >= 2});
      chk("R6 stat0",        {15'b0, stat0},        {15'b0, mStage == 3});
      chk("R6 dataEnable",   {15'b0, dataEnable},   {15'b0, mStage == 3});
      chk("R7 readyForData", {15'b0, readyForData}, {15'b0, mRdy});
      chk("R2 rxEnabled",    {15'b0, rxEnabled},    {15'b0, mRx});
      chk("R5 freqDetEn",    {15'b0, freqDetEn},    {15'b0, mRx && (mStage < 2)});
      chk("R9 txWord",       txWord,                mWord);
      chk("R11 no 01",       {15'b0, (!stat1 && stat0)}, 16'h0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      hostData = W'($urandom);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    started = 1;
    #5;
    // R1: values held during reset
    chk("R1 stat in reset", {14'b0, stat1, stat0}, 16'h0);
    chk("R1 word in reset", txWord, F0);
    step(2);
    rstN = 1'b1;
    step(1);
    chk("R1 ready after reset", {15'b0, readyForData}, 16'h0);

    // R2 / R12: frame lock and early fill1 without transmitter lock
    frameLocked = 1'b1; fill1Seen = 1'b1;
    step(4);
    chk("R2 held at 00", {14'b0, stat1, stat0}, 16'h0);
    chk("R12 no skip", {15'b0, stat0}, 16'h0);
    chk("R3 fill0 word", txWord, F0);

    // R4: lock arrives, fill1Seen low
    fill1Seen = 1'b0; txLocked = 1'b1;
    step(1);
    chk("R4 enter 10", {14'b0, stat1, stat0}, 16'h2);
    step(3);
    chk("R4 fill1 word", txWord, F1);

    // R6 / R7
    fill1Seen = 1'b1;
    step(1);
    chk("R6 enter 11", {14'b0, stat1, stat0}, 16'h3);
    chk("R7 not yet", {15'b0, readyForData}, 16'h0);
    step(1);
    chk("R7 one edge", {15'b0, readyForData}, 16'h0);
    step(1);
    chk("R7 two edges", {15'b0, readyForData}, 16'h1);
    step(5);

    // R8: single-cycle frame lock drop, then recover (R10 with reset tied off)
    frameLocked = 1'b0;
    step(1);
    chk("R8 frame drop", {13'b0, stat1, stat0, readyForData}, 16'h0);
    frameLocked = 1'b1;
    step(6);
    chk("R10 self restart", {14'b0, stat1, stat0}, 16'h3);

    // R8: transmitter lock drop
    txLocked = 1'b0;
    step(1);
    chk("R8 tx drop", {13'b0, stat1, stat0, readyForData}, 16'h0);
    txLocked = 1'b1;
    step(5);

    // R10: receiver reset pulse
    rxSmRstN = 1'b0;
    step(1);
    chk("R10 rx reset", {14'b0, stat1, stat0}, 16'h0);
    rxSmRstN = 1'b1;
    step(5);

    // R1: power-on reset in the data stage
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(4);

    // Random flag activity
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      hostData    = W'($urandom);
      txLocked    = ($urandom % 40) != 0;
      frameLocked = ($urandom % 25) != 0;
      fill1Seen   = ($urandom % 4) == 0;
      rxSmRstN    = ($urandom % 60) != 0;
      rstN        = ($urandom % 500) != 0;
    end
    rstN = 1'b1;
    step(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule